// File: doc/BRIEF.md
# Register rename map table

This block sits between decode and dispatch. Each cycle it takes a group of up to two decoded instructions. Every instruction names one destination and two source architectural registers. The block returns, in the same cycle, the physical register tags those names resolve to.

Each instruction that writes a register is given a fresh physical tag from a free list, and the table is pointed at that tag. Earlier writers and readers keep the tags they already hold, so write-after-write and write-after-read conflicts disappear. Read-after-write dependencies survive as shared tags. Inside one group, the second instruction sees the first one's new mapping. Every renamed destination also reports the tag it displaced, so that commit can later hand that tag back.

A commit port updates a committed copy of the table and pushes displaced tags onto the free list. A flush restores the live table from the committed copy. It also reclaims every tag that was handed out but not committed. When the free list holds fewer tags than a group needs, the block raises stall and renames nothing in that cycle.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for every i in 0..15, stall is low, and the free list hands out tags 16, 17, ..., 47 in ascending order.
- R2: Outputs are combinational in the cycle of the request. Slot 0 occupies the low field of every packed bus. A source tag is the current table entry for that register, and an accepted write is visible to reads from the next cycle on.
- R3: When slot 1 reads a register that slot 0 writes in the same group, slot 1 receives slot 0's newly allocated tag instead of the table entry.
- R4: Each valid instruction with its write flag set receives the tag at the head of the free list, with slot 0 served before slot 1. An instruction whose write flag is clear consumes no tag, and its destination outputs are don't-care.
- R5: The old-tag output of a renamed destination is the mapping that destination had before the instruction. For slot 1 writing the same register as slot 0, the old tag is slot 0's new tag.
- R6: When ren_req is high and the number of writing instructions exceeds the free tags, stall is high, no tag is consumed and the table is unchanged. A group with no writing instruction never stalls.
- R7: A commit (cmt_vld bit set) writes cmt_new into the committed copy for cmt_arch and appends cmt_old to the tail of the free list, where later allocations reach it.
- R8: A flush restores every table entry from the committed copy. It also returns every allocated but uncommitted tag, so the next allocation is the oldest tag handed out since the last commit. Nothing is renamed in a flush cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_req | input | 1 | Rename request for the current group |
| slot_vld | input | 2 | Instruction present, per slot |
| slot_wr | input | 2 | Instruction writes a destination, per slot |
| slot_dst | input | 2*4 | Destination architectural index, per slot |
| slot_sa | input | 2*4 | First source architectural index, per slot |
| slot_sb | input | 2*4 | Second source architectural index, per slot |
| stall | output | 1 | Group not accepted for lack of free tags |
| ren_pa | output | 2*6 | First source physical tag, per slot |
| ren_pb | output | 2*6 | Second source physical tag, per slot |
| ren_pd | output | 2*6 | Newly allocated destination tag, per slot |
| ren_old | output | 2*6 | Tag displaced by the destination, per slot |
| cmt_vld | input | 2 | Commit of a register-writing instruction, per slot |
| cmt_arch | input | 2*4 | Committed destination architectural index |
| cmt_new | input | 2*6 | Tag that becomes the committed mapping |
| cmt_old | input | 2*6 | Displaced tag returned to the free list |
| flush | input | 1 | Restore table and free list to committed state |

## Verification
The assertions assume that commit traffic is in program order. Each commit reports exactly the new and old tags that rename produced for that instruction, so the free list never holds more than 32 tags. They also assume that slot 1 is interpreted only together with slot 0, so a group is a program-ordered pair. The stimulus commits only an instruction it has itself renamed, with the tags the block returned. It flushes only in a cycle without a rename request, and it drains the free list through a known sequence of writes so that every expected tag follows from the reset order.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NARCH = 16,
  parameter int NPHYS = 48,
  localparam int AW = $clog2(NARCH),
  localparam int TW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_req,
  input  logic [1:0]    slot_vld,
  input  logic [1:0]    slot_wr,
  input  logic [2*AW-1:0] slot_dst,
  input  logic [2*AW-1:0] slot_sa,
  input  logic [2*AW-1:0] slot_sb,
  output logic          stall,
  output logic [2*TW-1:0] ren_pa,
  output logic [2*TW-1:0] ren_pb,
  output logic [2*TW-1:0] ren_pd,
  output logic [2*TW-1:0] ren_old,
  input  logic [1:0]    cmt_vld,
  input  logic [2*AW-1:0] cmt_arch,
  input  logic [2*TW-1:0] cmt_new,
  input  logic [2*TW-1:0] cmt_old,
  input  logic          flush
);
  // free-list depth must be a power of two for the pointer arithmetic
  localparam int NFREE = NPHYS - NARCH;
  localparam int FW = $clog2(NFREE);

  logic [TW-1:0] map_q  [NARCH];
  logic [TW-1:0] cmap_q [NARCH];
  logic [TW-1:0] cmap_n [NARCH];
  logic [TW-1:0] fl_q   [NFREE];
  logic [FW:0]   head_q, chead_q, tail_q;

  wire [1:0]    wr   = slot_vld & slot_wr;
  wire [1:0]    need = {1'b0, wr[0]} + {1'b0, wr[1]};
  wire [1:0]    cnum = {1'b0, cmt_vld[0]} + {1'b0, cmt_vld[1]};
  wire [FW:0]   avail = tail_q - head_q;
  wire          fire = ren_req && !stall && !flush;

  wire [AW-1:0] d0 = slot_dst[AW-1:0], d1 = slot_dst[2*AW-1:AW];
  wire [AW-1:0] a0 = slot_sa[AW-1:0],  a1 = slot_sa[2*AW-1:AW];
  wire [AW-1:0] b0 = slot_sb[AW-1:0],  b1 = slot_sb[2*AW-1:AW];
  wire [AW-1:0] ca0 = cmt_arch[AW-1:0], ca1 = cmt_arch[2*AW-1:AW];

  wire [FW-1:0] h0 = head_q[FW-1:0];
  wire [FW-1:0] h1 = h0 + FW'(wr[0]);
  wire [FW-1:0] t0 = tail_q[FW-1:0];
  wire [FW-1:0] t1 = t0 + FW'(cmt_vld[0]);

  wire [TW-1:0] new0 = fl_q[h0];
  wire [TW-1:0] new1 = fl_q[h1];

  assign stall = ren_req && (avail < (FW+1)'(need));

  assign ren_pa  = {(wr[0] && a1 == d0) ? new0 : map_q[a1], map_q[a0]};
  assign ren_pb  = {(wr[0] && b1 == d0) ? new0 : map_q[b1], map_q[b0]};
  assign ren_pd  = {new1, new0};
  assign ren_old = {(wr[0] && d1 == d0) ? new0 : map_q[d1], map_q[d0]};

  always_comb begin
    cmap_n = cmap_q;
    if (cmt_vld[0]) cmap_n[ca0] = cmt_new[TW-1:0];
    if (cmt_vld[1]) cmap_n[ca1] = cmt_new[2*TW-1:TW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NARCH; i++) begin
        map_q[i]  <= TW'(i);
        cmap_q[i] <= TW'(i);
      end
      for (int j = 0; j < NFREE; j++) fl_q[j] <= TW'(NARCH + j);
      head_q  <= '0;
      chead_q <= '0;
      tail_q  <= (FW+1)'(NFREE);
    end else begin
      cmap_q  <= cmap_n;
      chead_q <= chead_q + (FW+1)'(cnum);
      tail_q  <= tail_q + (FW+1)'(cnum);
      if (cmt_vld[0]) fl_q[t0] <= cmt_old[TW-1:0];
      if (cmt_vld[1]) fl_q[t1] <= cmt_old[2*TW-1:TW];
      if (flush) begin
        map_q  <= cmap_n;
        head_q <= chead_q + (FW+1)'(cnum);
      end else if (fire) begin
        head_q <= head_q + (FW+1)'(need);
        if (wr[0]) map_q[d0] <= new0;
        if (wr[1]) map_q[d1] <= new1;
      end
    end
  end
endmodule

module rename_map_chk #(
  parameter int AW = 4,
  parameter int TW = 6,
  parameter int FW = 5,
  parameter int NFREE = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ren_req,
  input logic [1:0]      slot_vld,
  input logic [1:0]      slot_wr,
  input logic [2*AW-1:0] slot_dst,
  input logic [2*AW-1:0] slot_sa,
  input logic            stall,
  input logic            flush,
  input logic [2*TW-1:0] ren_pa,
  input logic [2*TW-1:0] ren_pd,
  input logic [2*TW-1:0] ren_old,
  input logic [FW:0]     head_q,
  input logic [FW:0]     tail_q
);
  wire [1:0] w = slot_vld & slot_wr;
  wire ok = ren_req && !stall && !flush;

  a_r6_no_write_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_req && w == 2'b00) |-> !stall);

  a_r6_stall_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> head_q == $past(head_q));

  a_r4_distinct_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && w == 2'b11) |-> ren_pd[TW-1:0] != ren_pd[2*TW-1:TW]);

  a_r3_group_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && w[0] && slot_vld[1] && slot_sa[2*AW-1:AW] == slot_dst[AW-1:0])
      |-> ren_pa[2*TW-1:TW] == ren_pd[TW-1:0]);

  a_r5_old_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && w == 2'b11 && slot_dst[AW-1:0] == slot_dst[2*AW-1:AW])
      |-> ren_old[2*TW-1:TW] == ren_pd[TW-1:0]);

  a_r7_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) <= (FW+1)'(NFREE));
endmodule

bind rename_map rename_map_chk #(.AW(AW), .TW(TW), .FW(FW), .NFREE(NFREE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_req(ren_req), .slot_vld(slot_vld),
  .slot_wr(slot_wr), .slot_dst(slot_dst), .slot_sa(slot_sa), .stall(stall),
  .flush(flush), .ren_pa(ren_pa), .ren_pd(ren_pd), .ren_old(ren_old),
  .head_q(head_q), .tail_q(tail_q)
);

// File: tb/rename_map_test.sv
module rename_map_test;
  logic clk = 1'b0, rst_n = 1'b0, ren_req = 1'b0, flush = 1'b0;
  logic [1:0] slot_vld = '0, slot_wr = '0, cmt_vld = '0;
  logic [7:0] slot_dst = '0, slot_sa = '0, slot_sb = '0, cmt_arch = '0;
  logic [11:0] cmt_new = '0, cmt_old = '0;
  logic stall;
  logic [11:0] ren_pa, ren_pb, ren_pd, ren_old;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  rename_map uut (.*);

  // per slot: {vld, wr, dst, sa, sb}; entry = {slot1, slot0}
  localparam logic [27:0] STIM [4] = '{
    {1'b1,1'b1,4'd4,4'd3,4'd5, 1'b1,1'b1,4'd3,4'd1,4'd2},
    {1'b1,1'b1,4'd3,4'd3,4'd0, 1'b1,1'b1,4'd3,4'd3,4'd4},
    {1'b1,1'b1,4'd7,4'd3,4'd4, 1'b1,1'b0,4'd0,4'd3,4'd7},
    {1'b0,1'b0,4'd0,4'd0,4'd0, 1'b1,1'b1,4'd5,4'd7,4'd7}
  };
  // {old1, pd1, pb1, pa1, old0, pd0, pb0, pa0}
  localparam logic [47:0] EXPV [4] = '{
    {6'd4,  6'd17, 6'd5,  6'd16, 6'd3,  6'd16, 6'd2,  6'd1},
    {6'd18, 6'd19, 6'd0,  6'd18, 6'd16, 6'd18, 6'd17, 6'd16},
    {6'd7,  6'd20, 6'd17, 6'd19, 6'd0,  6'd0,  6'd7,  6'd19},
    {6'd0,  6'd0,  6'd0,  6'd0,  6'd5,  6'd21, 6'd20, 6'd20}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] sl(input bit v, input bit w, input int d, input int a, input int b);
    return {v, w, 4'(d), 4'(a), 4'(b)};
  endfunction

  task automatic put(input logic [13:0] s0, input logic [13:0] s1);
    slot_vld = {s1[13], s0[13]};
    slot_wr  = {s1[12], s0[12]};
    slot_dst = {s1[11:8], s0[11:8]};
    slot_sa  = {s1[7:4], s0[7:4]};
    slot_sb  = {s1[3:0], s0[3:0]};
  endtask

  task automatic step(input logic [13:0] s0, input logic [13:0] s1);
    @(negedge clk);
    ren_req = 1'b1;
    put(s0, s1);
    #1;
  endtask

  localparam logic [13:0] NONE = 14'd0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: identity mapping after reset, read only
    for (int i = 0; i < 4; i++) begin
      step(sl(1, 0, 0, 4*i, 4*i+1), sl(1, 0, 0, 4*i+2, 4*i+3));
      chk("R1 stall", int'(stall), 0);
      chk("R1 pa0", int'(ren_pa[5:0]), 4*i);
      chk("R1 pb0", int'(ren_pb[5:0]), 4*i+1);
      chk("R1 pa1", int'(ren_pa[11:6]), 4*i+2);
      chk("R1 pb1", int'(ren_pb[11:6]), 4*i+3);
    end

    // R2 R3 R4 R5: vector table
    for (int k = 0; k < 4; k++) begin
      step(STIM[k][13:0], STIM[k][27:14]);
      chk("R2 pa0", int'(ren_pa[5:0]), int'(EXPV[k][5:0]));
      chk("R2 pb0", int'(ren_pb[5:0]), int'(EXPV[k][11:6]));
      if (STIM[k][12]) begin
        chk("R4 pd0", int'(ren_pd[5:0]), int'(EXPV[k][17:12]));
        chk("R5 old0", int'(ren_old[5:0]), int'(EXPV[k][23:18]));
      end
      if (STIM[k][27]) begin
        chk("R3 pa1", int'(ren_pa[11:6]), int'(EXPV[k][29:24]));
        chk("R3 pb1", int'(ren_pb[11:6]), int'(EXPV[k][35:30]));
        chk("R4 pd1", int'(ren_pd[11:6]), int'(EXPV[k][41:36]));
        chk("R5 old1", int'(ren_old[11:6]), int'(EXPV[k][47:42]));
      end
    end

    // R4: drain the free list through R8
    for (int g = 0; g < 12; g++) begin
      step(sl(1, 1, 8, 0, 0), sl(1, 1, 8, 0, 0));
      chk("R4 drain pd0", int'(ren_pd[5:0]), 22 + 2*g);
      chk("R4 drain pd1", int'(ren_pd[11:6]), 23 + 2*g);
    end
    step(sl(1, 1, 8, 0, 0), NONE);
    chk("R4 pd single", int'(ren_pd[5:0]), 46);

    // R6: one tag left, group wants two
    step(sl(1, 1, 2, 0, 0), sl(1, 1, 6, 0, 0));
    chk("R6 stall short", int'(stall), 1);
    step(sl(1, 0, 0, 8, 2), sl(1, 0, 0, 6, 0));
    chk("R6 no-write stall", int'(stall), 0);
    chk("R6 map R8 kept", int'(ren_pa[5:0]), 46);
    chk("R6 map R2 kept", int'(ren_pb[5:0]), 2);
    chk("R6 map R6 kept", int'(ren_pa[11:6]), 6);
    step(sl(1, 1, 9, 0, 0), NONE);
    chk("R6 last tag stall", int'(stall), 0);
    chk("R4 last tag", int'(ren_pd[5:0]), 47);
    chk("R5 old R9", int'(ren_old[5:0]), 9);
    step(sl(1, 1, 10, 0, 0), NONE);
    chk("R6 empty stall", int'(stall), 1);
    step(sl(1, 0, 10, 10, 0), NONE);
    chk("R6 empty no-write", int'(stall), 0);
    chk("R6 R10 unchanged", int'(ren_pa[5:0]), 10);

    // R7: commit first write of R3, returning tag 3
    @(negedge clk);
    ren_req = 1'b0;
    put(NONE, NONE);
    cmt_vld = 2'b01; cmt_arch = 8'd3; cmt_new = 12'd16; cmt_old = 12'd3;
    @(negedge clk);
    cmt_vld = 2'b00;
    ren_req = 1'b1;
    put(sl(1, 1, 11, 0, 0), NONE);
    #1;
    chk("R7 stall", int'(stall), 0);
    chk("R7 released tag", int'(ren_pd[5:0]), 3);
    chk("R7 old R11", int'(ren_old[5:0]), 11);

    // R8: flush back to committed state
    @(negedge clk);
    ren_req = 1'b0;
    put(NONE, NONE);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    step(sl(1, 0, 0, 3, 4), sl(1, 0, 0, 11, 8));
    chk("R8 R3 committed", int'(ren_pa[5:0]), 16);
    chk("R8 R4 restored", int'(ren_pb[5:0]), 4);
    chk("R8 R11 restored", int'(ren_pa[11:6]), 11);
    chk("R8 R8 restored", int'(ren_pb[11:6]), 8);
    step(sl(1, 1, 12, 3, 0), sl(1, 1, 12, 12, 0));
    chk("R8 stall", int'(stall), 0);
    chk("R8 reclaimed pd0", int'(ren_pd[5:0]), 17);
    chk("R8 old0", int'(ren_old[5:0]), 12);
    chk("R8 reclaimed pd1", int'(ren_pd[11:6]), 18);
    chk("R5 old1 chain", int'(ren_old[11:6]), 17);
    chk("R3 src bypass", int'(ren_pa[11:6]), 17);

    @(negedge clk);
    ren_req = 1'b0;
    put(NONE, NONE);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule